// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block holds a circular ring of receive descriptors in its own storage and walks it one descriptor at a time. Each descriptor carries a 32-bit status word, a buffer size, a byte count and a link to the next descriptor. The receive DMA engine, which is outside the block, fills a buffer and then writes the finished status word and byte count through a completion port. Writing a status word with the ownership bit clear hands the descriptor back.

The manager watches the descriptor at its current position. While that descriptor is still owned by the DMA, the manager waits and counts the cycles. Once ownership is clear, the manager classifies the frame. It is accepted only when the single descriptor carries both the start-of-frame and end-of-frame marks and has no error. An accepted frame is reported with its length minus the two alignment bytes that sit in front of the data. The manager then re-arms the descriptor for the DMA and follows the link to the next one.

A peek port lets the DMA side, or a test, read any descriptor's fields directly.

Top module: `rx_ring_mgr`

## Requirements
- R1: Out of reset, every descriptor holds status 0x8080_0000, meaning ownership bit 31 and interrupt-enable bit 23 are set. Every buffer size equals BUF_BYTES, every byte count is zero, the current index is 0, and no result pulse is active.
- R2: While bit 31 of the current descriptor's status is set, no accept or drop pulse is produced and the current index does not move. This holds even after a completion write that leaves bit 31 set.
- R3: A descriptor is ready when bit 31 is clear. If a ready descriptor has bit 17 (first) and bit 16 (last) set and bit 15 (error) clear, `frm_ok` pulses for one cycle on the clock edge after the completion write lands. `frm_len` then equals the byte count minus two, floored at zero.
- R4: A ready descriptor that lacks bit 17 or bit 16 produces a one-cycle `frm_drop` pulse, and `frm_len` equals the raw byte count.
- R5: A ready descriptor with bit 15 set produces `frm_drop`, even when bits 17 and 16 are both set.
- R6: On the edge that processes a descriptor, that descriptor is rewritten to status 0x8080_0000, buffer size BUF_BYTES and byte count 0.
- R7: Each processed descriptor moves the current index along its link. The links run from entry i to entry i+1, and the last entry links back to entry 0.
- R8: After TMO_CYC consecutive edges spent waiting on an owned descriptor, `wait_tmo` pulses for one cycle. The wait count restarts after each pulse and whenever a descriptor is processed.
- R9: At most one of `frm_ok`, `frm_drop` and `wait_tmo` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_we | input | 1 | Completion write strobe from the DMA |
| cpl_idx | input | IW | Descriptor index being completed |
| cpl_stat | input | 32 | Status word written on completion |
| cpl_cnt | input | CW | Received byte count written on completion |
| peek_idx | input | IW | Descriptor index to read back |
| peek_stat | output | 32 | Status word of the peeked descriptor |
| peek_size | output | CW | Buffer size of the peeked descriptor |
| peek_cnt | output | CW | Byte count of the peeked descriptor |
| cur_idx | output | IW | Descriptor the manager is waiting on |
| frm_ok | output | 1 | One-cycle accept pulse |
| frm_drop | output | 1 | One-cycle drop pulse |
| frm_len | output | CW | Length for the current accept or drop pulse |
| wait_tmo | output | 1 | One-cycle ownership-wait timeout pulse |

## Verification
A wrong classification shows up at the very next edge after a completion lands. In that case the pulse type or the reported length disagrees with the scoreboard entry pushed when the completion was driven. A broken link or index register shows up as a `cur_idx` mismatch on that same pulse. A descriptor that is not re-armed shows up on the next peek, and again a full ring later as an early frame. A timeout counter that restarts at the wrong moment is caught at its first pulse, because each pulse's distance from the previous pulse or processed descriptor must be exactly TMO_CYC edges.

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
  parameter int DEPTH     = 8,
  parameter int CW        = 16,
  parameter int BUF_BYTES = 1536,
  parameter int TMO_CYC   = 1000,
  localparam int IW = $clog2(DEPTH),
  localparam int TW = $clog2(TMO_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpl_we,
  input  logic [IW-1:0] cpl_idx,
  input  logic [31:0]   cpl_stat,
  input  logic [CW-1:0] cpl_cnt,
  input  logic [IW-1:0] peek_idx,
  output logic [31:0]   peek_stat,
  output logic [CW-1:0] peek_size,
  output logic [CW-1:0] peek_cnt,
  output logic [IW-1:0] cur_idx,
  output logic          frm_ok,
  output logic          frm_drop,
  output logic [CW-1:0] frm_len,
  output logic          wait_tmo
);
  localparam logic [31:0] REARM = 32'h8080_0000;
  localparam int B_OWN = 31, B_FIRST = 17, B_LAST = 16, B_ERR = 15;

  logic [31:0]   st_q  [DEPTH];
  logic [CW-1:0] sz_q  [DEPTH];
  logic [CW-1:0] cnt_q [DEPTH];
  logic [IW-1:0] nxt_q [DEPTH];
  logic [IW-1:0] cur_q;
  logic [TW-1:0] tcnt_q;

  logic          ready, good;
  logic [CW-1:0] ccnt;

  assign ready = ~st_q[cur_q][B_OWN];
  assign good  = st_q[cur_q][B_FIRST] & st_q[cur_q][B_LAST] & ~st_q[cur_q][B_ERR];
  assign ccnt  = cnt_q[cur_q];

  assign peek_stat = st_q[peek_idx];
  assign peek_size = sz_q[peek_idx];
  assign peek_cnt  = cnt_q[peek_idx];
  assign cur_idx   = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]  <= REARM;
        sz_q[i]  <= CW'(BUF_BYTES);
        cnt_q[i] <= '0;
        nxt_q[i] <= (i == DEPTH-1) ? '0 : IW'(i+1);
      end
    end else begin
      if (cpl_we) begin
        st_q[cpl_idx]  <= cpl_stat;
        cnt_q[cpl_idx] <= cpl_cnt;
      end
      if (ready) begin
        st_q[cur_q]  <= REARM;
        sz_q[cur_q]  <= CW'(BUF_BYTES);
        cnt_q[cur_q] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= '0;
      tcnt_q   <= '0;
      frm_ok   <= 1'b0;
      frm_drop <= 1'b0;
      frm_len  <= '0;
      wait_tmo <= 1'b0;
    end else begin
      frm_ok   <= ready & good;
      frm_drop <= ready & ~good;
      if (ready) begin
        cur_q    <= nxt_q[cur_q];
        frm_len  <= !good ? ccnt : (ccnt >= CW'(2)) ? ccnt - CW'(2) : '0;
        tcnt_q   <= '0;
        wait_tmo <= 1'b0;
      end else if (tcnt_q == TW'(TMO_CYC-1)) begin
        tcnt_q   <= '0;
        wait_tmo <= 1'b1;
      end else begin
        tcnt_q   <= tcnt_q + 1'b1;
        wait_tmo <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_ring_chk.sv
module rx_ring_chk #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] cur_idx,
  input logic          frm_ok,
  input logic          frm_drop,
  input logic          wait_tmo
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frm_ok, frm_drop, wait_tmo}));  // R9

  AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_ok || frm_drop) |->
      cur_idx == (($past(cur_idx) == IW'(DEPTH-1)) ? IW'(0) : IW'($past(cur_idx) + 1'b1)));  // R7

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_ok || frm_drop) |-> $stable(cur_idx));  // R2

  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wait_tmo |=> !wait_tmo);  // R8
endmodule

bind rx_ring_mgr rx_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_idx(cur_idx),
  .frm_ok(frm_ok), .frm_drop(frm_drop), .wait_tmo(wait_tmo)
);

// File: tb/tb_rx_ring_mgr.sv
module tb_rx_ring_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int CW = 16;
  localparam int BUF = 1536;
  localparam int TMO = 20;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpl_we = 1'b0;
  logic [IW-1:0] cpl_idx = '0, peek_idx = '0;
  logic [31:0] cpl_stat = '0;
  logic [CW-1:0] cpl_cnt = '0;
  logic [31:0] peek_stat;
  logic [CW-1:0] peek_size, peek_cnt, frm_len;
  logic [IW-1:0] cur_idx;
  logic frm_ok, frm_drop, wait_tmo;

  int checks = 0, fails = 0;
  int cyc = 0, last_ev = -1;
  logic [IW-1:0] exp_cur = '0;
  logic [CW:0] expq[$];

  rx_ring_mgr #(.DEPTH(DEPTH), .CW(CW), .BUF_BYTES(BUF), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .cpl_we(cpl_we), .cpl_idx(cpl_idx),
    .cpl_stat(cpl_stat), .cpl_cnt(cpl_cnt), .peek_idx(peek_idx),
    .peek_stat(peek_stat), .peek_size(peek_size), .peek_cnt(peek_cnt),
    .cur_idx(cur_idx), .frm_ok(frm_ok), .frm_drop(frm_drop),
    .frm_len(frm_len), .wait_tmo(wait_tmo));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected item per result pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (frm_ok || frm_drop || wait_tmo)
        chk($countones({frm_ok, frm_drop, wait_tmo}) == 1, "R9",
            {frm_ok, frm_drop, wait_tmo}, 0);
      if (frm_ok || frm_drop) begin
        if (expq.size() == 0) begin
          chk(0, "R2 unexpected pulse", {frm_drop, frm_len}, 0);
        end else begin
          logic [CW:0] e;
          e = expq.pop_front();
          chk({frm_drop, frm_len} == e, e[CW] ? "R4/R5 drop" : "R3 accept",
              {frm_drop, frm_len}, e);
        end
        exp_cur = (exp_cur == IW'(DEPTH-1)) ? '0 : exp_cur + 1'b1;
        chk(cur_idx == exp_cur, "R7 link", cur_idx, exp_cur);
        last_ev = cyc;
      end
      if (wait_tmo) begin
        if (last_ev >= 0) chk(cyc - last_ev == TMO, "R8 gap", cyc - last_ev, TMO);
        last_ev = cyc;
      end
    end
  end

  task automatic complete(input int idx, input logic [31:0] st, input int cnt,
                          input bit drop, input int len);
    @(negedge clk);
    cpl_we = 1'b1; cpl_idx = IW'(idx); cpl_stat = st; cpl_cnt = CW'(cnt);
    if (!st[31]) expq.push_back({drop, CW'(len)});
  endtask

  task automatic idle(input int n);
    @(negedge clk); cpl_we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic peek_armed(input int idx, input string req);
    peek_idx = IW'(idx); #1;
    chk(peek_stat == 32'h8080_0000, req, peek_stat, 32'h8080_0000);
    chk(peek_size == CW'(BUF), req, peek_size, BUF);
    chk(peek_cnt == '0, req, peek_cnt, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cur_idx == 0, "R1 cur", cur_idx, 0);
    chk(!frm_ok && !frm_drop, "R1 pulses", {frm_ok, frm_drop}, 0);
    for (int i = 0; i < DEPTH; i++) peek_armed(i, "R1 armed");
    // R2: still owned after a write that keeps bit 31
    complete(0, 32'h8003_0000, 100, 0, 0);
    idle(5);
    chk(cur_idx == 0, "R2 hold", cur_idx, 0);
    peek_idx = 0; #1;
    chk(peek_cnt == CW'(100), "R2 written", peek_cnt, 100);
    // R3..R5 across the ring
    complete(0, 32'h0003_0000, 100, 0, 98);     // R3
    complete(1, 32'h0002_0000, 60, 1, 60);      // R4 first only
    complete(2, 32'h0001_0000, 61, 1, 61);      // R4 last only
    complete(3, 32'h0003_8000, 70, 1, 70);      // R5 error
    complete(4, 32'h0003_0000, BUF, 0, BUF-2);  // R3 full buffer
    complete(5, 32'h0003_0000, 2, 0, 0);        // R3 floor
    complete(6, 32'h0000_0000, 40, 1, 40);      // R4 neither
    complete(7, 32'h0003_0000, 64, 0, 62);      // R3, wraps ring
    idle(3);
    chk(cur_idx == 0, "R7 wrap", cur_idx, 0);
    chk(expq.size() == 0, "R3 drained", expq.size(), 0);
    for (int i = 0; i < DEPTH; i++) peek_armed(i, "R6 rearm");
    // R8: timeouts while waiting, restart after a processed frame
    idle(3 * TMO);
    complete(0, 32'h0003_0000, 10, 0, 8);
    idle(2 * TMO + 5);
    chk(expq.size() == 0, "R3 last", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule